// File: doc/BRIEF.md
# Memory-Mapped Machine Timer Comparator

This peripheral keeps a free-running 64-bit tick counter and a 64-bit compare value, and raises a machine timer-pending level toward the core whenever the counter has reached the compare value. Software reaches both 64-bit registers over a 32-bit register bus, one 32-bit word per access. Byte enables select which bytes of a word a store changes. A constant-rate tick strobe advances the counter, and core activity does not affect it. The block also drives a full-width, read-only copy of the counter that the core can use as its time CSR.

The pending output is a plain level taken from an unsigned greater-or-equal compare of the two registers. It has no latch and no acknowledge. Firmware clears it by storing a later deadline. On a 32-bit bus, firmware rewrites the deadline in three stores: all ones to the low word, then the new high word, then the new low word. None of the intermediate values can produce a false pending.

Top module: `mtimer_cmp`

## Requirements
- R1: After reset the counter reads zero, the compare register reads all ones, and timer_pending is low.
- R2: The word at byte offset 0x0 is counter bits 31:0, 0x4 is counter bits 63:32, 0x8 is compare bits 31:0 and 0xC is compare bits 63:32. Address bits 1:0 are ignored. A read returns the addressed word in the same cycle. bus_rdata is zero when no read is in progress.
- R3: On a write, bus_be[i] set replaces bits 8i+7:8i of the addressed word with the same bits of bus_wdata. Bytes whose enable is clear keep their value.
- R4: timer_pending is high exactly when the counter is greater than or equal to the compare value, taken as unsigned 64-bit numbers. It follows the register contents in both directions with no added delay.
- R5: Once timer_pending is high it stays high while the registers are unchanged. Idle cycles and reads do not clear it. A register write that puts the compare value above the counter clears it.
- R6: The counter increments by one after each clock edge where tick_en is high, and holds otherwise.
- R7: When the low counter word rolls over from 0xFFFFFFFF to 0, the high word increments on the same clock edge.
- R8: In a cycle with a counter write, the tick is dropped for the whole counter. The written bytes take the bus data, and every other byte keeps its value from before that cycle.
- R9: time_shadow equals the 64-bit counter every cycle, as read through offsets 0x0 and 0x4.
- R10: The three-store compare update (low word all ones, new high word, new low word) never raises timer_pending if the counter stays below both the old-high/new-high intermediate values and the final deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Constant-rate tick strobe |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Read data of the addressed word |
| timer_pending | output | 1 | Machine timer-pending level |
| time_shadow | output | 64 | Read-only copy of the counter |

## Verification
On every cycle, the assertions check the following. The counter moves only by a tick or a write. The carry into the high word comes on the same edge as the low-word rollover. A written counter half drops the tick. The compare register changes only when written. The pending level rises or falls only after a tick or a register write. The bench scenarios show what no single-cycle property can. These are the full byte-enable sweep over all four words, the pending boundary around equality (including across the word seam), the persistence of pending through idle cycles and reads, and the absence of any false pending during the three-store deadline update while the counter is running.

// File: rtl/mtimer_pkg.sv
`timescale 1ns/1ps
package mtimer_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int BE_W    = WORD_W / BYTE_W;
  localparam int CNT_W   = 2 * WORD_W;
  localparam int NUM_REG = 4;
  localparam int IDX_W   = $clog2(NUM_REG);

  // Word indices: the map order is fixed by the bus decode.
  localparam logic [IDX_W-1:0] IDX_CNT_LO = 2'd0;
  localparam logic [IDX_W-1:0] IDX_CNT_HI = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CMP_LO = 2'd2;
  localparam logic [IDX_W-1:0] IDX_CMP_HI = 2'd3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  wide_t;

  // Replace the enabled bytes of old_w with the matching bytes of new_w.
  function automatic word_t be_merge(word_t old_w, word_t new_w, logic [BE_W-1:0] be);
    word_t r;
    r = old_w;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  // One word of an incrementer: returns {carry_out, sum}.
  function automatic logic [WORD_W:0] word_inc(word_t w, logic cin);
    return {1'b0, w} + {{WORD_W{1'b0}}, cin};
  endfunction

  // Unsigned a >= b, decided on the high words first, then the low words.
  function automatic logic wide_ge(wide_t a, wide_t b);
    logic hi_gt, hi_eq, lo_ge;
    hi_gt = a[CNT_W-1:WORD_W] > b[CNT_W-1:WORD_W];
    hi_eq = a[CNT_W-1:WORD_W] == b[CNT_W-1:WORD_W];
    lo_ge = a[WORD_W-1:0] >= b[WORD_W-1:0];
    return hi_gt | (hi_eq & lo_ge);
  endfunction

endpackage

// File: rtl/mtimer_word.sv
`timescale 1ns/1ps
module mtimer_word
  import mtimer_pkg::*;
#(
  parameter word_t RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  word_t           wdata,
  input  logic [BE_W-1:0] be,
  input  logic            ld_en,
  input  word_t           ld_val,
  output word_t           q
);

  // A bus write outranks the internal load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      q <= be_merge(q, wdata, be);
    end else if (ld_en) begin
      q <= ld_val;
    end
  end

endmodule

// File: rtl/mtimer_regif.sv
`timescale 1ns/1ps
module mtimer_regif
  import mtimer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  word_t [NUM_REG-1:0]       words,
  output logic  [NUM_REG-1:0]       wr_en,
  output word_t                     rdata
);

  localparam int LSB_W = $clog2(BE_W);

  logic [IDX_W-1:0] widx;
  logic             rd_act;
  logic             wr_act;
  logic             unused_addr;

  assign widx        = bus_addr[LSB_W +: IDX_W];
  assign unused_addr = ^{1'b0, bus_addr[LSB_W-1:0], bus_addr[ADDR_W-1:LSB_W+IDX_W-1]};
  assign rd_act      = bus_sel & ~bus_we;
  assign wr_act      = bus_sel & bus_we;

  for (genvar i = 0; i < NUM_REG; i++) begin : g_dec
    assign wr_en[i] = wr_act & (widx == IDX_W'(i));
  end

  always_comb begin
    rdata = '0;
    if (rd_act) rdata = words[widx];
  end

endmodule

// File: rtl/mtimer_counter.sv
`timescale 1ns/1ps
module mtimer_counter
  import mtimer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic [1:0]      wr_half,
  input  word_t           wdata,
  input  logic [BE_W-1:0] be,
  output wide_t           cnt,
  output logic            lo_carry,
  output logic            tick_take
);

  word_t [1:0]  half_q;
  word_t [1:0]  half_nxt;
  logic  [WORD_W:0] lo_sum;
  logic  [WORD_W:0] hi_sum;

  // Split incrementer: the low carry feeds the high word in the same cycle.
  assign lo_sum   = word_inc(half_q[0], 1'b1);
  assign lo_carry = lo_sum[WORD_W];
  assign hi_sum   = word_inc(half_q[1], lo_carry);
  assign half_nxt[0] = lo_sum[WORD_W-1:0];
  assign half_nxt[1] = hi_sum[WORD_W-1:0];

  // Any counter write drops the tick for both halves.
  assign tick_take = tick_en & ~(|wr_half);

  for (genvar h = 0; h < 2; h++) begin : g_half
    mtimer_word #(.RST_VAL('0)) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_half[h]),
      .wdata  (wdata),
      .be     (be),
      .ld_en  (tick_take),
      .ld_val (half_nxt[h]),
      .q      (half_q[h])
    );
  end

  assign cnt = {half_q[1], half_q[0]};

endmodule

// File: rtl/mtimer_compare.sv
`timescale 1ns/1ps
module mtimer_compare
  import mtimer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      wr_half,
  input  word_t           wdata,
  input  logic [BE_W-1:0] be,
  input  wide_t           cnt,
  output wide_t           cmp,
  output logic            pending
);

  word_t [1:0] half_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    mtimer_word #(.RST_VAL('1)) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_half[h]),
      .wdata  (wdata),
      .be     (be),
      .ld_en  (1'b0),
      .ld_val ('0),
      .q      (half_q[h])
    );
  end

  assign cmp     = {half_q[1], half_q[0]};
  // Pure level: no state between the registers and the output.
  assign pending = wide_ge(cnt, cmp);

endmodule

// File: rtl/mtimer_cmp.sv
`timescale 1ns/1ps
module mtimer_cmp
  import mtimer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  output logic              timer_pending,
  output logic [63:0]       time_shadow
);

  wide_t                cnt_q;
  wide_t                cmp_q;
  logic  [NUM_REG-1:0]  wr_en;
  word_t [NUM_REG-1:0]  words;
  logic                 lo_carry;
  logic                 tick_take;

  assign words[IDX_CNT_LO] = cnt_q[WORD_W-1:0];
  assign words[IDX_CNT_HI] = cnt_q[CNT_W-1:WORD_W];
  assign words[IDX_CMP_LO] = cmp_q[WORD_W-1:0];
  assign words[IDX_CMP_HI] = cmp_q[CNT_W-1:WORD_W];

  mtimer_regif #(.ADDR_W(ADDR_W)) u_regif (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .words    (words),
    .wr_en    (wr_en),
    .rdata    (bus_rdata)
  );

  mtimer_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_half   ({wr_en[IDX_CNT_HI], wr_en[IDX_CNT_LO]}),
    .wdata     (bus_wdata),
    .be        (bus_be),
    .cnt       (cnt_q),
    .lo_carry  (lo_carry),
    .tick_take (tick_take)
  );

  mtimer_compare u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_half ({wr_en[IDX_CMP_HI], wr_en[IDX_CMP_LO]}),
    .wdata   (bus_wdata),
    .be      (bus_be),
    .cnt     (cnt_q),
    .cmp     (cmp_q),
    .pending (timer_pending)
  );

  assign time_shadow = cnt_q;

endmodule

// File: rtl/mtimer_cmp_chk.sv
`timescale 1ns/1ps
module mtimer_cmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic [3:0]  wr_en,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic        pending,
  input logic        carry
);

  logic any_cnt_wr;
  logic any_wr;
  assign any_cnt_wr = wr_en[0] | wr_en[1];
  assign any_wr     = |wr_en;

  // R6
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !any_wr) |=> $stable(cnt));

  // R6
  tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !any_cnt_wr) |=> (cnt[31:0] == $past(cnt[31:0]) + 32'd1));

  // R7
  carry_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !any_cnt_wr) |=>
      (cnt[63:32] == $past(cnt[63:32]) + {31'd0, $past(carry)}));

  // R8
  lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && !wr_en[1]) |=> $stable(cnt[63:32]));

  // R8
  hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[1] && !wr_en[0]) |=> $stable(cnt[31:0]));

  // R5
  cmp_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en[2] || wr_en[3]) |=> $stable(cmp));

  // R5
  pending_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(any_wr));

  // R4
  pending_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(any_wr || tick_en));

endmodule

bind mtimer_cmp mtimer_cmp_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .wr_en   (wr_en),
  .cnt     (cnt_q),
  .cmp     (cmp_q),
  .pending (timer_pending),
  .carry   (lo_carry)
);

// File: tb/mtimer_cmp_tb_top.sv
`timescale 1ns/1ps
module mtimer_cmp_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        timer_pending;
  logic [63:0] time_shadow;

  int errors = 0;
  int checks = 0;
  logic [63:0] m_cnt;
  logic [63:0] m_cmp;

  always #10 clk = ~clk;  // 50 MHz

  mtimer_cmp #(.ADDR_W(4)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_be        (bus_be),
    .bus_rdata     (bus_rdata),
    .timer_pending (timer_pending),
    .time_shadow   (time_shadow)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench's own byte merge: mask built from enables, then blended.
  function automatic logic [31:0] blend(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (n & m) | (o & ~m);
  endfunction

  function automatic logic exp_pend(logic [63:0] c, logic [63:0] k);
    return !(c < k);
  endfunction

  // Write word idx; returns at the falling edge after the storing edge.
  task automatic wr(int idx, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1;
    bus_addr = 4'(idx * 4 + (idx % 4));  // low address bits vary (R2)
    bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    case (idx)
      0: m_cnt[31:0]  = blend(m_cnt[31:0], d, be);
      1: m_cnt[63:32] = blend(m_cnt[63:32], d, be);
      2: m_cmp[31:0]  = blend(m_cmp[31:0], d, be);
      default: m_cmp[63:32] = blend(m_cmp[63:32], d, be);
    endcase
  endtask

  task automatic rd(int idx, output logic [31:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'(idx * 4);
    #2 q = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] mword(int idx);
    case (idx)
      0: return m_cnt[31:0];
      1: return m_cnt[63:32];
      2: return m_cmp[31:0];
      default: return m_cmp[63:32];
    endcase
  endfunction

  task automatic set_cnt(logic [63:0] v);
    wr(1, v[63:32], 4'hF);
    wr(0, v[31:0], 4'hF);
  endtask

  task automatic set_cmp(logic [63:0] v);
    wr(2, 32'hFFFF_FFFF, 4'hF);
    wr(3, v[63:32], 4'hF);
    wr(2, v[31:0], 4'hF);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] q;
    logic [63:0] start;
    m_cnt = '0;
    m_cmp = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd(i, q);
      check("R1 reset word", {32'd0, q}, {32'd0, mword(i)});
    end
    check("R1 pending after reset", {63'd0, timer_pending}, 64'd0);
    @(negedge clk);
    check("R2 rdata idle", {32'd0, bus_rdata}, 64'd0);

    // R3/R2/R4: every byte-enable pattern on every word
    for (int r = 0; r < 4; r++) begin
      for (int be = 0; be < 16; be++) begin
        wr(r, {8'(r), 8'(be), 8'(be * 7 + r), 8'(255 - be)}, 4'(be));
        rd(r, q);
        check("R3 byte-enable write", {32'd0, q}, {32'd0, mword(r)});
        check("R4 pending vs model", {63'd0, timer_pending},
              {63'd0, exp_pend(m_cnt, m_cmp)});
        check("R9 shadow", time_shadow, m_cnt);
      end
    end

    // R4: boundary sweep around equality, inside a word and across the seam
    set_cmp(64'h0000_0001_0000_0010);
    for (int d = -3; d <= 3; d++) begin
      set_cnt(64'h0000_0001_0000_0010 + 64'(signed'(d)));
      check("R4 boundary", {63'd0, timer_pending}, {63'd0, (d >= 0)});
    end
    set_cmp(64'h0000_0005_0000_0000);
    set_cnt(64'h0000_0004_FFFF_FFFF);
    check("R4 seam below", {63'd0, timer_pending}, 64'd0);
    set_cnt(64'h0000_0005_0000_0000);
    check("R4 seam equal", {63'd0, timer_pending}, 64'd1);

    // R6/R7/R9: ticking across the low-word rollover, sampled each cycle
    set_cnt(64'h0000_0007_FFFF_FFFD);
    start = m_cnt;
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check("R7 tick with carry", time_shadow, start + 64'(i));
    end
    tick_en = 1'b0;
    m_cnt = start + 64'd5;
    @(negedge clk);
    check("R6 holds without tick", time_shadow, m_cnt);
    rd(1, q);
    check("R7 high word after rollover", {32'd0, q}, 64'h8);
    rd(0, q);
    check("R9 low word read", {32'd0, q}, 64'h2);

    // R8: counter write during a tick drops the tick
    set_cnt(64'h0000_0002_1122_3344);
    @(negedge clk);
    tick_en = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h0;
    bus_wdata = 32'hAABB_CCDD; bus_be = 4'b0011;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R8 write beats tick", time_shadow, 64'h0000_0002_1122_CCDD);
    @(negedge clk);
    check("R8 tick resumes", time_shadow, 64'h0000_0002_1122_CCDE);
    tick_en = 1'b0;
    @(negedge clk);
    m_cnt = time_shadow;
    check("R6 stops with tick low", time_shadow, 64'h0000_0002_1122_CCDE);

    // R5: pending persists until a later deadline is stored
    set_cnt(64'd100);
    wr(3, 32'd0, 4'hF);
    wr(2, 32'd50, 4'hF);
    check("R5 pending set", {63'd0, timer_pending}, 64'd1);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 4; i++) rd(i, q);
    @(negedge clk);
    check("R5 pending survives idle and reads", {63'd0, timer_pending}, 64'd1);
    wr(2, 32'd200, 4'hF);
    check("R5 cleared by later deadline", {63'd0, timer_pending}, 64'd0);

    // R10: three-store update while the counter runs
    set_cnt(64'h0000_0003_FFFF_FF00);
    wr(3, 32'd3, 4'hF);
    wr(2, 32'h0000_0010, 4'hF);
    check("R10 old deadline pending", {63'd0, timer_pending}, 64'd1);
    @(negedge clk);
    tick_en = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_be = 4'hF;
    bus_addr = 4'h8; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R10 after low all-ones", {63'd0, timer_pending}, 64'd0);
    bus_addr = 4'hC; bus_wdata = 32'd5;
    @(negedge clk);
    check("R10 after new high", {63'd0, timer_pending}, 64'd0);
    bus_addr = 4'h8; bus_wdata = 32'd10;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R10 after new low", {63'd0, timer_pending}, 64'd0);
    repeat (4) begin
      @(negedge clk);
      check("R10 stays low while running", {63'd0, timer_pending}, 64'd0);
    end
    tick_en = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule